// File: doc/BRIEF.md
# LPC Host Command Front End

This block is the register face of a host-side LPC controller. A processor on a simple 32-bit register bus writes a command word, a byte count and a target address, and fills a transmit byte queue through one data register. It then writes a start register. The block passes the command fields to an LPC cycle engine and issues a one-cycle start request. It waits for the engine's done indication and records the result.

When the engine reports completion, the block returns to idle and records whether the transfer succeeded. It also sets an interrupt status bit, which software clears by writing a one to it. Bytes the engine receives go into a receive byte queue. Software drains that queue by repeatedly reading a single data register. The LPC pin timing belongs to the engine and is not part of this block.

Register bus writes take effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr`. A read of the receive data register pops one byte at the edge on which `reg_rd` is high.

Top module: `lpc_cmd_frontend`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x1 (bit 0 idle set, bit 1 success clear). The interrupt status register (0x08), length (0x10), command (0x14) and address (0x20) registers read 0. `irq` is low, `eng_start` is low and both byte queues are empty.
- R2: The command register (0x14) keeps bits [3:0] and reads back zeros above them. Bit 0 drives `eng_write` (1 = write, 0 = read). Bits [2:1] drive `eng_cyc_type` (0 I/O, 1 memory, 2 firmware-hub). Bit 3 drives `eng_same_addr` (1 = every byte to one address, 0 = incrementing address).
- R3: The length register (0x10) stores a written value from 0 to 16 and leaves its contents unchanged for any larger value. Its contents drive `eng_len`.
- R4: The address register (0x20) holds 32 bits, reads back what was written, and drives `eng_addr`.
- R5: A write to the start register (0x00) with bit 0 set, while idle and with a non-zero length, raises `eng_start` for exactly the one cycle after the write edge. At that same point the idle bit reads 0. A start write with bit 0 clear does nothing.
- R6: A start write while the block is not idle produces no `eng_start` pulse.
- R7: `eng_done` while busy returns the block to idle, copies `eng_ok` into status bit 1, and sets interrupt status bit 1 (register value 0x2). This also drives `irq` high.
- R8: A start with length 0 produces no `eng_start`. After the write edge the block is idle, status bit 1 is clear and interrupt status bit 1 is set.
- R9: Writing 1 to bit 1 of the interrupt status register clears it. Writing 0 there leaves it set.
- R10: Each write to 0x24 pushes data bits [7:0] into the 16-byte transmit queue, and a push into a full queue is dropped. The engine sees the oldest byte on `eng_tx_data` while `eng_tx_avail` is high, and `eng_tx_pop` removes it.
- R11: `eng_rx_push` stores `eng_rx_data` in the 16-byte receive queue, and a push into a full queue is dropped. Each read of 0x28 returns the oldest byte in bits [7:0] and removes it. A read of an empty queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, mirrors interrupt status bit 1 |
| eng_start | output | 1 | One-cycle start request to the cycle engine |
| eng_write | output | 1 | Transfer direction, 1 = write |
| eng_cyc_type | output | 2 | Cycle type: 0 I/O, 1 memory, 2 firmware-hub |
| eng_same_addr | output | 1 | 1 = fixed address, 0 = incrementing address |
| eng_addr | output | 32 | Transfer start address |
| eng_len | output | 5 | Transfer byte count |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_tx_pop | input | 1 | Engine consumes the oldest transmit byte |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_rx_push | input | 1 | Store `eng_rx_data` in the receive queue |
| eng_done | input | 1 | Engine finished the transfer |
| eng_ok | input | 1 | Result qualifier for `eng_done`, 1 = success |

## Verification
The bench builds the block with its defaults: 8-bit offsets and 16-entry queues, so the length limit is 16. With a depth of 16, a few dozen bus accesses fill each queue to capacity. That brings the dropped seventeenth byte and the empty-read zero into reach, along with the 16-versus-17 edge of the length register. The default depth also keeps the pointer wrap from last entry to first in play during the full-queue drains.

// File: rtl/lpc_fe_pkg.sv
// Package: shared register offsets, command layout and sequencer states
// for the LPC host command front end.
package lpc_fe_pkg;

    // Register byte offsets seen by software
    localparam int unsigned OFS_START  = 32'h00;
    localparam int unsigned OFS_STATUS = 32'h04;
    localparam int unsigned OFS_IRQ    = 32'h08;
    localparam int unsigned OFS_LEN    = 32'h10;
    localparam int unsigned OFS_CMD    = 32'h14;
    localparam int unsigned OFS_ADDR   = 32'h20;
    localparam int unsigned OFS_TXDATA = 32'h24;
    localparam int unsigned OFS_RXDATA = 32'h28;

    // Command word, bit 0 = direction (LSB of the packed struct)
    typedef struct packed {
        logic       same_addr;  // bit 3
        logic [1:0] cyc_type;   // bits 2:1
        logic       is_write;   // bit 0
    } cmd_t;

    typedef enum logic [1:0] {
        CYC_IO   = 2'd0,
        CYC_MEM  = 2'd1,
        CYC_FWH  = 2'd2
    } cyc_type_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/lpc_fe_fifo.sv
// Module: lpc_fe_fifo
// Synchronous byte queue with first-word fall-through output.
// Assumes: push into a full queue is dropped, pop of an empty queue is a
// no-op. Push and pop may coincide. DEPTH need not be a power of two.
module lpc_fe_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    logic do_push;
    logic do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Advance a pointer with wrap at the last entry
    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on accepted push
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R10 R11
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(wr_ptr)));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(rd_ptr)));

endmodule

// File: rtl/lpc_fe_seq.sv
// Module: lpc_fe_seq
// Transfer sequencer: launches the cycle engine, tracks idle/busy, records
// the result and owns the write-one-to-clear completion flag.
// Assumes: start_req is a decoded start-register write with bit 0 set;
// eng_done is only meaningful while busy. A completion in the same cycle
// as a clear wins.
module lpc_fe_seq
    import lpc_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic len_zero,
    input  logic irq_clr,
    input  logic eng_done,
    input  logic eng_ok,
    output logic eng_start,
    output logic idle,
    output logic finished,
    output logic irq_st
);
    seq_state_e state;

    assign idle = (state == SEQ_IDLE);

    // Sequencer state, start pulse, result and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            eng_start <= 1'b0;
            finished  <= 1'b0;
            irq_st    <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            if (irq_clr) irq_st <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start_req) begin
                        finished <= 1'b0;
                        if (len_zero) begin
                            irq_st <= 1'b1;
                        end else begin
                            state     <= SEQ_BUSY;
                            eng_start <= 1'b1;
                        end
                    end
                end
                SEQ_BUSY: begin
                    if (eng_done) begin
                        state    <= SEQ_IDLE;
                        finished <= eng_ok;
                        irq_st   <= 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R5
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_req && !len_zero) |=> (eng_start && !idle));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && start_req) |=> !eng_start);

    // R7
    complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && eng_done) |=> (idle && irq_st && (finished == $past(eng_ok))));

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_req && len_zero) |=> (idle && irq_st && !finished && !eng_start));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && idle && !start_req) |=> !irq_st);

endmodule

// File: rtl/lpc_cmd_frontend.sv
// Module: lpc_cmd_frontend
// Register front end for a host LPC controller: command, length, address,
// start, status and completion-flag registers plus transmit and receive
// byte queues reached through single data registers.
// Assumes: writes act at the edge with reg_wr high; read data is
// combinational; a receive-data read pops at the edge with reg_rd high.
module lpc_cmd_frontend
    import lpc_fe_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic                             reg_wr,
    input  logic                             reg_rd,
    input  logic [31:0]                      reg_wdata,
    output logic [31:0]                      reg_rdata,
    output logic                             irq,
    output logic                             eng_start,
    output logic                             eng_write,
    output logic [1:0]                       eng_cyc_type,
    output logic                             eng_same_addr,
    output logic [31:0]                      eng_addr,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]  eng_len,
    output logic [7:0]                       eng_tx_data,
    output logic                             eng_tx_avail,
    input  logic                             eng_tx_pop,
    input  logic [7:0]                       eng_rx_data,
    input  logic                             eng_rx_push,
    input  logic                             eng_done,
    input  logic                             eng_ok
);
    localparam int LEN_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(OFS_START);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_IRQ    = ADDR_W'(OFS_IRQ);
    localparam logic [ADDR_W-1:0] A_LEN    = ADDR_W'(OFS_LEN);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_ADDR   = ADDR_W'(OFS_ADDR);
    localparam logic [ADDR_W-1:0] A_TXDATA = ADDR_W'(OFS_TXDATA);
    localparam logic [ADDR_W-1:0] A_RXDATA = ADDR_W'(OFS_RXDATA);

    cmd_t             cmd_q;
    logic [LEN_W-1:0] len_q;
    logic [31:0]      addr_q;

    logic idle, finished, irq_st;
    logic start_req, irq_clr;
    logic tx_push, tx_empty, tx_full;
    logic rx_pop, rx_empty, rx_full;
    logic [7:0] rx_head;

    // Bus write decode
    assign start_req = reg_wr && (reg_addr == A_START) && reg_wdata[0];
    assign irq_clr   = reg_wr && (reg_addr == A_IRQ) && reg_wdata[1];
    assign tx_push   = reg_wr && (reg_addr == A_TXDATA);
    assign rx_pop    = reg_rd && (reg_addr == A_RXDATA);

    // Configuration registers: command, length (0..depth only), address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            len_q  <= '0;
            addr_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CMD)  cmd_q  <= cmd_t'(reg_wdata[3:0]);
            if (reg_addr == A_ADDR) addr_q <= reg_wdata;
            if (reg_addr == A_LEN && reg_wdata <= 32'(FIFO_DEPTH))
                len_q <= LEN_W'(reg_wdata);
        end
    end

    // Command fields toward the cycle engine
    assign eng_write     = cmd_q.is_write;
    assign eng_cyc_type  = cmd_q.cyc_type;
    assign eng_same_addr = cmd_q.same_addr;
    assign eng_addr      = addr_q;
    assign eng_len       = len_q;
    assign eng_tx_avail  = !tx_empty;
    assign irq           = irq_st;

    lpc_fe_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .len_zero  (len_q == '0),
        .irq_clr   (irq_clr),
        .eng_done  (eng_done),
        .eng_ok    (eng_ok),
        .eng_start (eng_start),
        .idle      (idle),
        .finished  (finished),
        .irq_st    (irq_st)
    );

    lpc_fe_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (reg_wdata[7:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    lpc_fe_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    // Bus read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS: reg_rdata = {30'd0, finished, idle};
            A_IRQ:    reg_rdata = {30'd0, irq_st, 1'b0};
            A_LEN:    reg_rdata = 32'(len_q);
            A_CMD:    reg_rdata = 32'(cmd_q);
            A_ADDR:   reg_rdata = addr_q;
            A_RXDATA: reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
            default:  reg_rdata = '0;
        endcase
    end

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_len <= LEN_W'(FIFO_DEPTH)));

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> ($past(idle) && !idle));

    // R10
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !eng_tx_pop) |=> tx_full);

    // R11
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |-> (reg_rdata == 32'd0));

endmodule

// File: tb/test_lpc_cmd_frontend.sv
module test_lpc_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, eng_start, eng_write, eng_same_addr, eng_tx_avail;
    logic [1:0]  eng_cyc_type;
    logic [31:0] eng_addr;
    logic [4:0]  eng_len;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_rx_push = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_ok = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    lpc_cmd_frontend i_lpc_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .eng_start(eng_start), .eng_write(eng_write),
        .eng_cyc_type(eng_cyc_type), .eng_same_addr(eng_same_addr),
        .eng_addr(eng_addr), .eng_len(eng_len), .eng_tx_data(eng_tx_data),
        .eng_tx_avail(eng_tx_avail), .eng_tx_pop(eng_tx_pop),
        .eng_rx_data(eng_rx_data), .eng_rx_push(eng_rx_push),
        .eng_done(eng_done), .eng_ok(eng_ok)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic engine_done(input bit ok);
        @(negedge clk);
        eng_done = 1'b1; eng_ok = ok;
        @(negedge clk);
        eng_done = 1'b0; eng_ok = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(8'h04, v); chk_eq("R1 status", v, 32'h1);
        reg_read(8'h08, v); chk_eq("R1 irq reg", v, 32'h0);
        reg_read(8'h10, v); chk_eq("R1 len", v, 32'h0);
        reg_read(8'h14, v); chk_eq("R1 cmd", v, 32'h0);
        reg_read(8'h20, v); chk_eq("R1 addr", v, 32'h0);
        chk_eq("R1 irq pin", {31'd0, irq}, 32'h0);
        chk_eq("R1 eng_start", {31'd0, eng_start}, 32'h0);
        chk_eq("R1 tx empty", {31'd0, eng_tx_avail}, 32'h0);
        reg_read(8'h28, v); chk_eq("R1 R11 rx empty read", v, 32'h0);
    endtask

    task automatic t_cmd;
        logic [31:0] v;
        reg_write(8'h14, 32'h0000000D);
        chk_eq("R2 write dir", {31'd0, eng_write}, 32'h1);
        chk_eq("R2 fwh type", {30'd0, eng_cyc_type}, 32'h2);
        chk_eq("R2 same addr", {31'd0, eng_same_addr}, 32'h1);
        reg_write(8'h14, 32'hFFFFFFF2);
        reg_read(8'h14, v); chk_eq("R2 readback mask", v, 32'h2);
        chk_eq("R2 read dir", {31'd0, eng_write}, 32'h0);
        chk_eq("R2 mem type", {30'd0, eng_cyc_type}, 32'h1);
        chk_eq("R2 inc addr", {31'd0, eng_same_addr}, 32'h0);
    endtask

    task automatic t_len_addr;
        logic [31:0] v;
        reg_write(8'h10, 32'd16);
        reg_read(8'h10, v); chk_eq("R3 len 16", v, 32'd16);
        reg_write(8'h10, 32'd17);
        reg_read(8'h10, v); chk_eq("R3 len 17 ignored", v, 32'd16);
        chk_eq("R3 eng_len", {27'd0, eng_len}, 32'd16);
        reg_write(8'h10, 32'd3);
        reg_read(8'h10, v); chk_eq("R3 len 3", v, 32'd3);
        reg_write(8'h20, 32'h12345678);
        reg_read(8'h20, v); chk_eq("R4 addr readback", v, 32'h12345678);
        chk_eq("R4 eng_addr", eng_addr, 32'h12345678);
    endtask

    task automatic t_tx;
        for (int i = 0; i < 17; i++) reg_write(8'h24, 32'hAB00 + 32'(8'h10 + i));
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk_eq("R10 tx avail", {31'd0, eng_tx_avail}, 32'h1);
            chk_eq("R10 tx order", {24'd0, eng_tx_data}, 32'(8'h10 + i));
            eng_tx_pop = 1'b1;
            @(posedge clk);
            #1 eng_tx_pop = 1'b0;
        end
        @(negedge clk);
        chk_eq("R10 17th byte dropped", {31'd0, eng_tx_avail}, 32'h0);
    endtask

    task automatic t_start_ok;
        logic [31:0] v;
        reg_write(8'h10, 32'd4);
        reg_write(8'h00, 32'h2);
        chk_eq("R5 bit0 clear no start", {31'd0, eng_start}, 32'h0);
        reg_write(8'h00, 32'h1);
        chk_eq("R5 start pulse", {31'd0, eng_start}, 32'h1);
        #1 v = reg_rdata;
        reg_read(8'h04, v); chk_eq("R5 not idle", v, 32'h0);
        chk_eq("R5 pulse one cycle", {31'd0, eng_start}, 32'h0);
        reg_write(8'h00, 32'h1);
        chk_eq("R6 start while busy", {31'd0, eng_start}, 32'h0);
        engine_done(1'b1);
        reg_read(8'h04, v); chk_eq("R7 status ok", v, 32'h3);
        reg_read(8'h08, v); chk_eq("R7 irq reg", v, 32'h2);
        chk_eq("R7 irq pin", {31'd0, irq}, 32'h1);
        reg_write(8'h08, 32'h1);
        reg_read(8'h08, v); chk_eq("R9 write 0 keeps", v, 32'h2);
        reg_write(8'h08, 32'h2);
        reg_read(8'h08, v); chk_eq("R9 w1c clears", v, 32'h0);
        chk_eq("R9 irq pin low", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_len0;
        logic [31:0] v;
        reg_write(8'h10, 32'd0);
        reg_write(8'h00, 32'h1);
        chk_eq("R8 no start", {31'd0, eng_start}, 32'h0);
        reg_read(8'h04, v); chk_eq("R8 idle, not finished", v, 32'h1);
        reg_read(8'h08, v); chk_eq("R8 irq set", v, 32'h2);
        reg_write(8'h08, 32'h2);
    endtask

    task automatic t_fail;
        logic [31:0] v;
        reg_write(8'h10, 32'd1);
        reg_write(8'h00, 32'h1);
        chk_eq("R5 second start", {31'd0, eng_start}, 32'h1);
        engine_done(1'b0);
        reg_read(8'h04, v); chk_eq("R7 status fail", v, 32'h1);
        reg_read(8'h08, v); chk_eq("R7 irq on fail", v, 32'h2);
        reg_write(8'h08, 32'h2);
    endtask

    task automatic t_rx;
        logic [31:0] v;
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            eng_rx_data = 8'h80 + 8'(i); eng_rx_push = 1'b1;
            @(posedge clk);
            #1 eng_rx_push = 1'b0;
        end
        for (int i = 0; i < 16; i++) begin
            reg_read(8'h28, v);
            chk_eq("R11 rx order", v, 32'(8'h80 + i));
        end
        reg_read(8'h28, v); chk_eq("R11 17th dropped, empty 0", v, 32'h0);
        reg_read(8'h28, v); chk_eq("R11 empty read again", v, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd();
        t_len_addr();
        t_tx();
        t_start_ok();
        t_len0();
        t_fail();
        t_rx();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule